// File: doc/BRIEF.md
# Two-Key Register Write Guard

This block sits between a peripheral's register bus and the configuration registers of a timekeeping unit. It watches every bus write. Writes to the guarded registers (time, date, control and prescaler) only reach their targets after software has put a two-word unlock sequence into a dedicated guard register. The unlock sequence is a first key followed immediately by a second key. Any other value written to the guard register closes the gate again.

The block does not hold the protected registers. It produces one qualifier, `regWrEn`, which the register file ANDs into its write strobes. It also produces a `locked` flag. Writes to addresses outside the guarded set pass through untouched. A write to the guard register itself never passes, so that register reads back as zero in any register file that uses the qualifier.

Top module: `keyguard`

## Requirements
- R1: After reset the block is locked: `locked` is 1, and a write to a guarded address gives `regWrEn` = 0.
- R2: A write of 0x000000CA to the guard address 0x24, followed by the next bus write being 0x00000053 to 0x24, clears `locked` on the clock edge that takes the second write.
- R3: While locked, a write to any guarded address (0x00, 0x04, 0x08, 0x10) gives `regWrEn` = 0 in the same cycle, so the write is dropped.
- R4: While unlocked, a write to a guarded address gives `regWrEn` = 1 in the same cycle.
- R5: A write to an address that is neither guarded nor 0x24 gives `regWrEn` = 1 in the same cycle, whatever the lock state.
- R6: A write to the guard address 0x24 never asserts `regWrEn`.
- R7: While unlocked, a write to 0x24 of any value other than 0x000000CA sets `locked` from the next cycle.
- R8: A write of 0x00000053 to 0x24 that does not directly follow 0x000000CA leaves or puts the block in the locked state.
- R9: Any bus write to another address between the two keys cancels the sequence: a following 0x00000053 does not unlock.
- R10: A write of 0x000000CA in any state, including unlocked or already armed, locks the block and arms the sequence, so a following 0x00000053 unlocks it.
- R11: Keys are compared over the whole data word: 0x000001CA does not act as the first key, and 0x0000FF53 does not act as the second key.
- R12: Cycles without a bus write change nothing: an armed sequence survives idle cycles, and the lock state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Bus write strobe, one write per cycle it is high |
| busAddr | input | ADDR_W (8) | Byte address of the write |
| busWrData | input | DATA_W (32) | Write data |
| regWrEn | output | 1 | Qualified write enable for the addressed register |
| locked | output | 1 | High while guarded registers refuse writes |

## Verification
`regWrEn` is a combinational function of the current write and the registered lock state, so it is due in the same cycle as the write. The bench samples it one time unit after driving the write at the falling edge, before the rising edge that consumes it. `locked` changes on the rising edge that takes a key write, so it is due one edge later. The bench reads it one time unit after that rising edge. Both sample points keep clear of the active edge.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;

  typedef enum logic [1:0] {
    GS_LOCKED = 2'd0,
    GS_ARMED  = 2'd1,
    GS_OPEN   = 2'd2
  } guardState_t;

  // datapath -> control: decoded bus events of the current cycle
  typedef struct packed {
    logic keyWr;      // write to the guard register
    logic firstKey;   // that write carries the first key
    logic secondKey;  // that write carries the second key
    logic otherWr;    // write to any other address
  } busEvent_t;

  // control -> datapath
  typedef struct packed {
    logic open;
  } ctrlStrobe_t;

endpackage

// File: rtl/keyguard_datapath.sv
module keyguard_datapath
  import keyguard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h24,
  parameter logic [DATA_W-1:0] FIRST_KEY = 'hCA,
  parameter logic [DATA_W-1:0] SECOND_KEY = 'h53,
  parameter int NUM_PROT = 4,
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LIST = {8'h10, 8'h08, 8'h04, 8'h00}
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  ctrlStrobe_t       strobe,
  output busEvent_t         evt,
  output logic              regWrEn
);

  logic [NUM_PROT-1:0] hitVec;
  logic                protHit;
  logic                keyHit;

  for (genvar g = 0; g < NUM_PROT; g++) begin : gen_prot_cmp
    assign hitVec[g] = (busAddr == PROT_LIST[g*ADDR_W +: ADDR_W]);
  end

  assign protHit = |hitVec;
  assign keyHit  = (busAddr == KEY_ADDR);

  always_comb begin
    evt.keyWr     = busWrEn & keyHit;
    evt.firstKey  = busWrEn & keyHit & (busWrData == FIRST_KEY);
    evt.secondKey = busWrEn & keyHit & (busWrData == SECOND_KEY);
    evt.otherWr   = busWrEn & ~keyHit;
  end

  // The guard register is never a storage target; guarded ones need the gate open.
  assign regWrEn = busWrEn & ~keyHit & (~protHit | strobe.open);

endmodule

// File: rtl/keyguard_ctrl.sv
module keyguard_ctrl
  import keyguard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  busEvent_t   evt,
  output ctrlStrobe_t strobe
);

  guardState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (evt.keyWr) begin
      if ((state == GS_ARMED) && evt.secondKey) begin
        stateNext = GS_OPEN;
      end else if (evt.firstKey) begin
        stateNext = GS_ARMED;
      end else begin
        stateNext = GS_LOCKED;
      end
    end else if (evt.otherWr && (state == GS_ARMED)) begin
      stateNext = GS_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= GS_LOCKED;
    end else begin
      state <= stateNext;
    end
  end

  assign strobe.open = (state == GS_OPEN);

endmodule

// File: rtl/keyguard.sv
module keyguard
  import keyguard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h24,
  parameter logic [DATA_W-1:0] FIRST_KEY = 'hCA,
  parameter logic [DATA_W-1:0] SECOND_KEY = 'h53,
  parameter int NUM_PROT = 4,
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LIST = {8'h10, 8'h08, 8'h04, 8'h00}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic              regWrEn,
  output logic              locked
);

  busEvent_t   evt;
  ctrlStrobe_t strobe;

  keyguard_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .KEY_ADDR  (KEY_ADDR),
    .FIRST_KEY (FIRST_KEY),
    .SECOND_KEY(SECOND_KEY),
    .NUM_PROT  (NUM_PROT),
    .PROT_LIST (PROT_LIST)
  ) u_datapath (
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .strobe   (strobe),
    .evt      (evt),
    .regWrEn  (regWrEn)
  );

  keyguard_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .evt   (evt),
    .strobe(strobe)
  );

  assign locked = ~strobe.open;

endmodule

// File: rtl/keyguard_chk.sv
module keyguard_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h24,
  parameter logic [DATA_W-1:0] FIRST_KEY = 'hCA,
  parameter logic [DATA_W-1:0] SECOND_KEY = 'h53,
  parameter int NUM_PROT = 4,
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LIST = {8'h10, 8'h08, 8'h04, 8'h00}
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              regWrEn,
  input logic              locked
);

  logic guardedAddr;
  logic keyAddrWr;

  always_comb begin
    guardedAddr = 1'b0;
    for (int i = 0; i < NUM_PROT; i++) begin
      if (busAddr == PROT_LIST[i*ADDR_W +: ADDR_W]) guardedAddr = 1'b1;
    end
  end

  assign keyAddrWr = busWrEn && (busAddr == KEY_ADDR);

  // R1
  reset_locked_chk: assert property (@(posedge clk) !rstN |=> locked);

  // R3
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && locked && guardedAddr && !keyAddrWr) |-> !regWrEn);

  // R4
  open_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !locked && guardedAddr && !keyAddrWr) |-> regWrEn);

  // R5
  free_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !guardedAddr && !keyAddrWr) |-> regWrEn);

  // R6
  key_never_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyAddrWr |-> !regWrEn);

  // R7
  relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyAddrWr && (busWrData != FIRST_KEY) && (busWrData != SECOND_KEY)) |=> locked);

  // R2
  unlock_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(keyAddrWr && (busWrData == SECOND_KEY)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(locked));

endmodule

bind keyguard keyguard_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .KEY_ADDR  (KEY_ADDR),
  .FIRST_KEY (FIRST_KEY),
  .SECOND_KEY(SECOND_KEY),
  .NUM_PROT  (NUM_PROT),
  .PROT_LIST (PROT_LIST)
) u_keyguard_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .regWrEn  (regWrEn),
  .locked   (locked)
);

// File: tb/tb_keyguard.sv
module tb_keyguard;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_GUARD = 8'h24;
  localparam logic [7:0] A_TIME  = 8'h00;
  localparam logic [7:0] A_DATE  = 8'h04;
  localparam logic [7:0] A_CTRL  = 8'h08;
  localparam logic [7:0] A_PRE   = 8'h10;
  localparam logic [7:0] A_FREE  = 8'h30;
  localparam logic [31:0] K1 = 32'h0000_00CA;
  localparam logic [31:0] K2 = 32'h0000_0053;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        regWrEn;
  logic        locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  keyguard dut (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .regWrEn  (regWrEn),
    .locked   (locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkBit(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Drive one write for one cycle; regWrEn is due in that same cycle.
  task automatic doWrite(input logic [7:0] addr, input logic [31:0] data,
                         input logic expWr, input string tag);
    @(negedge clk);
    busWrEn   = 1'b1;
    busAddr   = addr;
    busWrData = data;
    #1;
    checkBit(regWrEn, expWr, tag, $sformatf("regWrEn addr %02h data %08h", addr, data));
    @(posedge clk);
    #1;
    busWrEn = 1'b0;
  endtask

  // locked is due one edge after the write; sampled just after that edge.
  task automatic expectLocked(input logic exp, input string tag);
    checkBit(locked, exp, tag, "locked");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic unlockSeq();
    doWrite(A_GUARD, K1, 1'b0, "R6");
    doWrite(A_GUARD, K2, 1'b0, "R6");
  endtask

  task automatic testReset();
    expectLocked(1'b1, "R1");
    doWrite(A_TIME, 32'h12, 1'b0, "R1");
    doWrite(A_PRE, 32'h7F, 1'b0, "R3");
    doWrite(A_CTRL, 32'h1, 1'b0, "R3");
    expectLocked(1'b1, "R3");
  endtask

  task automatic testUnlock();
    doWrite(A_GUARD, K1, 1'b0, "R6");
    expectLocked(1'b1, "R2");
    doWrite(A_GUARD, K2, 1'b0, "R6");
    expectLocked(1'b0, "R2");
    doWrite(A_DATE, 32'h0023_0101, 1'b1, "R4");
    doWrite(A_TIME, 32'h0012_3456, 1'b1, "R4");
    expectLocked(1'b0, "R4");
  endtask

  task automatic testFreeAddr();
    doWrite(A_FREE, 32'hABCD, 1'b1, "R5");
    expectLocked(1'b0, "R5");
    doWrite(A_GUARD, 32'hFF, 1'b0, "R6");
    doWrite(A_FREE, 32'h1234, 1'b1, "R5");
  endtask

  task automatic testRelock();
    unlockSeq();
    expectLocked(1'b0, "R7");
    doWrite(A_GUARD, 32'hFF, 1'b0, "R7");
    expectLocked(1'b1, "R7");
    doWrite(A_PRE, 32'h00FF_007F, 1'b0, "R3");
    unlockSeq();
    doWrite(A_GUARD, 32'h0, 1'b0, "R7");
    expectLocked(1'b1, "R7");
  endtask

  task automatic testBareSecondKey();
    doWrite(A_GUARD, K2, 1'b0, "R8");
    expectLocked(1'b1, "R8");
    unlockSeq();
    expectLocked(1'b0, "R8");
    doWrite(A_GUARD, K2, 1'b0, "R8");
    expectLocked(1'b1, "R8");
    doWrite(A_CTRL, 32'h40, 1'b0, "R8");
  endtask

  task automatic testInterrupted();
    doWrite(A_GUARD, K1, 1'b0, "R9");
    doWrite(A_FREE, 32'h5, 1'b1, "R9");
    doWrite(A_GUARD, K2, 1'b0, "R9");
    expectLocked(1'b1, "R9");
    doWrite(A_TIME, 32'h1, 1'b0, "R9");
  endtask

  task automatic testIdleGap();
    doWrite(A_GUARD, K1, 1'b0, "R12");
    idle(4);
    expectLocked(1'b1, "R12");
    doWrite(A_GUARD, K2, 1'b0, "R12");
    expectLocked(1'b0, "R12");
    idle(3);
    expectLocked(1'b0, "R12");
  endtask

  task automatic testRepeatFirstKey();
    doWrite(A_GUARD, K1, 1'b0, "R10");
    expectLocked(1'b1, "R10");
    doWrite(A_GUARD, K2, 1'b0, "R10");
    expectLocked(1'b0, "R10");
    doWrite(A_GUARD, 32'hFF, 1'b0, "R10");
    doWrite(A_GUARD, K1, 1'b0, "R10");
    doWrite(A_GUARD, K1, 1'b0, "R10");
    doWrite(A_GUARD, K2, 1'b0, "R10");
    expectLocked(1'b0, "R10");
    doWrite(A_PRE, 32'h1, 1'b1, "R10");
  endtask

  task automatic testWideWord();
    doWrite(A_GUARD, 32'hFF, 1'b0, "R11");
    doWrite(A_GUARD, 32'h0000_01CA, 1'b0, "R11");
    doWrite(A_GUARD, K2, 1'b0, "R11");
    expectLocked(1'b1, "R11");
    doWrite(A_GUARD, K1, 1'b0, "R11");
    doWrite(A_GUARD, 32'h0000_FF53, 1'b0, "R11");
    expectLocked(1'b1, "R11");
    doWrite(A_DATE, 32'h9, 1'b0, "R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testUnlock();
    testFreeAddr();
    testRelock();
    testBareSecondKey();
    testInterrupted();
    testIdleGap();
    testRepeatFirstKey();
    testWideWord();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule